// File: doc/BRIEF.md
# Multi-Pin Event Timestamp Capture

This block records the time at which an external event arrives on any of eight shared input pins. Three free-running time-of-day sources enter the block as buses. Each source carries a 64-bit seconds count and a 30-bit nanoseconds count. Every capture channel has its own configuration word. That word arms the channel, names the physical input the channel listens to, and names the time source it samples.

When an armed channel sees a rising edge on its input, it latches the selected source's seconds and nanoseconds into its own registers. It also sets a sticky status bit, which software clears by writing one to it. A single interrupt line is the OR of the status bits that an enable mask lets through.

A raw nanoseconds value in the 16-count window just below 2^30 belongs to the end of the previous second. Such a value is folded at capture time, so software always reads a consistent time.

Top module: `evt_stamp`

## Requirements
- R1: After reset, the status, enable, configuration and captured-time registers all read zero, and `irqOut` is low.
- R2: A channel captures only when its action field (config bits 1:0) is 1 (save) and its arm field (config bits 5:4) is 3. An action of 0 (idle), or an arm value of 0, suppresses capture.
- R3: Only a rising edge triggers a capture. The status bit and the captured time become visible exactly three clock edges after the edge at which the input is first sampled high. A falling edge causes no capture.
- R4: Config bits 17:16 select time source 0, 1 or 2. A value of 3 selects no source, and the channel then never captures.
- R5: Channel 7 always samples time source 0. Its source field reads back as 0 whatever was written.
- R6: Config bits 23:21 give the index of the physical input that triggers the channel. Channels that listen to other inputs are unaffected.
- R7: On capture, the channel's seconds-high word (address 0x10+ch), seconds-low word (0x18+ch) and nanoseconds word (0x20+ch, bits 29:0) hold the sampled time.
- R8: If the raw nanoseconds value is 0x3FFFFFF0 or above, the stored seconds are the sampled seconds minus one, with the borrow carried across the 32-bit word boundary. The stored nanoseconds are the raw low 4 bits plus 999999984. A raw value below 0x3FFFFFF0 is stored unchanged.
- R9: The status register (address 0x00, bit ch per channel) is sticky and is cleared by writing 1 to a bit. A capture in the same cycle as a clearing write leaves the bit set.
- R10: A new capture on a channel whose status bit is still set overwrites the stored time and keeps the status bit set.
- R11: `irqOut` is high exactly when some status bit is set whose enable bit (address 0x01, bits 7:0) is also set.
- R12: A configuration word (address 0x08+ch) reads back its four fields at their bit positions and zero elsewhere. The enable register reads back its 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous event inputs |
| todSec | input | 192 | Seconds of the three time sources, source d at bits 64d+63:64d |
| todNs | input | 90 | Nanoseconds of the three sources, source d at bits 30d+29:30d |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Word address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Masked interrupt request |

## Verification
A corrupted synchroniser or edge-history flop appears as a capture that fires one cycle early, fires one cycle late, or fires on a falling edge. The status read taken three edges after the input rises exposes it immediately. A wrong source select or a wrong input select shows up on that same read: either the wrong status bit is set, or the stored seconds hold one of the decoy values placed on the unselected sources. A faulty fold or borrow is seen in the captured words on the first read after the event. A status bit that clears or sticks wrongly changes `irqOut` in the next cycle.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int PIN_CNT   = 8;
  localparam int DOM_CNT   = 3;
  localparam int DOM_W     = 2;
  localparam int SEL_W     = $clog2(PIN_CNT);
  localparam int WORD_W    = 32;
  localparam int SEC_W     = 2 * WORD_W;
  localparam int NS_W      = 30;
  localparam int ADDR_W    = 6;
  localparam int FIXED_PIN = PIN_CNT - 1;

  localparam int ACT_LSB  = 0;
  localparam int ARM_LSB  = 4;
  localparam int DOM_LSB  = 16;
  localparam int SEL_LSB  = 21;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 6'h01;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 6'h08;
  localparam logic [ADDR_W-1:0] ADDR_SEC_HI = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_SEC_LO = 6'h18;
  localparam logic [ADDR_W-1:0] ADDR_NS     = 6'h20;

  localparam logic [1:0] ACT_SAVE = 2'd1;
  localparam logic [1:0] ARM_ON   = 2'd3;

  localparam logic [NS_W-1:0] NS_WRAP_MASK = 30'h3FFFFFF0;
  localparam logic [NS_W-1:0] NS_FOLD_BASE = 30'd999999984;

  typedef struct packed {
    logic [1:0]       act;
    logic [1:0]       arm;
    logic [DOM_W-1:0] dom;
    logic [SEL_W-1:0] sel;
  } pinCfgT;

  typedef struct packed {
    logic [PIN_CNT-1:0]            capture;
    logic [PIN_CNT-1:0][DOM_W-1:0] domain;
  } capStrobeT;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } stampT;

  function automatic stampT foldStamp(input logic [SEC_W-1:0] sec,
                                      input logic [NS_W-1:0] ns);
    stampT r;
    if ((ns & NS_WRAP_MASK) == NS_WRAP_MASK) begin
      r.sec = sec - SEC_W'(1);
      r.ns  = {{(NS_W-4){1'b0}}, ns[3:0]} + NS_FOLD_BASE;
    end else begin
      r.sec = sec;
      r.ns  = ns;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] packCfg(input pinCfgT c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ACT_LSB +: 2]     = c.act;
    w[ARM_LSB +: 2]     = c.arm;
    w[DOM_LSB +: DOM_W] = c.dom;
    w[SEL_LSB +: SEL_W] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/evt_stamp_ctrl.sv
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PIN_CNT-1:0]  pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output capStrobeT           strobe,
  output logic [PIN_CNT-1:0]  stickyVec,
  output logic [PIN_CNT-1:0]  enableVec,
  output logic [WORD_W-1:0]   ctrlRdData
);
  logic [PIN_CNT-1:0] syncA, syncB, lastB, riseVec;
  logic [PIN_CNT-1:0] capVec, clrMask;
  logic [PIN_CNT-1:0][DOM_W-1:0] domVec;
  pinCfgT cfgQ [PIN_CNT];
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // two-flop synchroniser followed by a history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      lastB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end
  assign riseVec = syncB & ~lastB;

  // configuration words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PIN_CNT; p++) cfgQ[p] <= '0;
    end else if (regWrEn) begin
      for (int p = 0; p < PIN_CNT; p++) begin
        if (regAddr == ADDR_CFG + ADDR_W'(p)) begin
          cfgQ[p].act <= regWrData[ACT_LSB +: 2];
          cfgQ[p].arm <= regWrData[ARM_LSB +: 2];
          cfgQ[p].dom <= (p == FIXED_PIN) ? '0 : regWrData[DOM_LSB +: DOM_W];
          cfgQ[p].sel <= regWrData[SEL_LSB +: SEL_W];
        end
      end
    end
  end

  // per-channel arming and trigger selection
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_chan
    logic [DOM_W-1:0] effDom;
    logic             armed;
    if (p == FIXED_PIN) begin : g_fixed
      assign effDom = '0;
    end else begin : g_free
      assign effDom = cfgQ[p].dom;
    end
    assign armed     = (cfgQ[p].act == ACT_SAVE) && (cfgQ[p].arm == ARM_ON);
    assign capVec[p] = armed && riseVec[cfgQ[p].sel] &&
                       (int'(effDom) < DOM_CNT);
    assign domVec[p] = effDom;
  end

  assign strobe = '{capture: capVec, domain: domVec};

  // sticky status, write one to clear; a capture in the same cycle wins
  assign clrMask = (regWrEn && regAddr == ADDR_STATUS) ?
                   regWrData[PIN_CNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyVec <= '0;
      enableVec <= '0;
    end else begin
      stickyVec <= (stickyVec & ~clrMask) | capVec;
      if (regWrEn && regAddr == ADDR_ENABLE) enableVec <= regWrData[PIN_CNT-1:0];
    end
  end

  always_comb begin
    ctrlRdData = '0;
    if (regAddr == ADDR_STATUS) ctrlRdData[PIN_CNT-1:0] = stickyVec;
    if (regAddr == ADDR_ENABLE) ctrlRdData[PIN_CNT-1:0] = enableVec;
    for (int p = 0; p < PIN_CNT; p++) begin
      if (regAddr == ADDR_CFG + ADDR_W'(p)) ctrlRdData = packCfg(cfgQ[p]);
    end
  end
endmodule

// File: rtl/evt_stamp_dpath.sv
module evt_stamp_dpath
  import evt_stamp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  capStrobeT                 strobe,
  input  logic [DOM_CNT*SEC_W-1:0]  todSec,
  input  logic [DOM_CNT*NS_W-1:0]   todNs,
  input  logic [ADDR_W-1:0]         regAddr,
  output logic [WORD_W-1:0]         dpRdData
);
  logic [SEC_W-1:0] secQ [PIN_CNT];
  logic [NS_W-1:0]  nsQ  [PIN_CNT];
  stampT            foldVec [PIN_CNT];

  // source mux and wrap fold per channel
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_src
    logic [SEC_W-1:0] selSec;
    logic [NS_W-1:0]  selNs;
    always_comb begin
      selSec = '0;
      selNs  = '0;
      for (int d = 0; d < DOM_CNT; d++) begin
        if (strobe.domain[p] == DOM_W'(d)) begin
          selSec = todSec[d*SEC_W +: SEC_W];
          selNs  = todNs[d*NS_W +: NS_W];
        end
      end
    end
    assign foldVec[p] = foldStamp(selSec, selNs);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PIN_CNT; p++) begin
        secQ[p] <= '0;
        nsQ[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < PIN_CNT; p++) begin
        if (strobe.capture[p]) begin
          secQ[p] <= foldVec[p].sec;
          nsQ[p]  <= foldVec[p].ns;
        end
      end
    end
  end

  always_comb begin
    dpRdData = '0;
    for (int p = 0; p < PIN_CNT; p++) begin
      if (regAddr == ADDR_SEC_HI + ADDR_W'(p)) dpRdData = secQ[p][SEC_W-1:WORD_W];
      if (regAddr == ADDR_SEC_LO + ADDR_W'(p)) dpRdData = secQ[p][WORD_W-1:0];
      if (regAddr == ADDR_NS + ADDR_W'(p))     dpRdData = WORD_W'(nsQ[p]);
    end
  end
endmodule

// File: rtl/evt_stamp.sv
module evt_stamp
  import evt_stamp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PIN_CNT-1:0]        pinIn,
  input  logic [DOM_CNT*SEC_W-1:0]  todSec,
  input  logic [DOM_CNT*NS_W-1:0]   todNs,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [WORD_W-1:0]         regWrData,
  output logic [WORD_W-1:0]         regRdData,
  output logic                      irqOut
);
  capStrobeT          capStrobe;
  logic [PIN_CNT-1:0] stickyVec, enableVec;
  logic [WORD_W-1:0]  ctrlRdData, dpRdData;

  evt_stamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(capStrobe), .stickyVec(stickyVec), .enableVec(enableVec),
    .ctrlRdData(ctrlRdData)
  );

  evt_stamp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(capStrobe),
    .todSec(todSec), .todNs(todNs),
    .regAddr(regAddr), .dpRdData(dpRdData)
  );

  assign regRdData = ctrlRdData | dpRdData;
  assign irqOut    = |(stickyVec & enableVec);
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk
  import evt_stamp_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [WORD_W-1:0]  regWrData,
  input logic [WORD_W-1:0]  regRdData,
  input logic               irqOut,
  input capStrobeT          capStrobe,
  input logic [PIN_CNT-1:0] stickyVec,
  input logic [PIN_CNT-1:0] enableVec
);
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    AST_CAPTURE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe.capture[p] |=> stickyVec[p]); // R9

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_STATUS && regWrData[p] && !capStrobe.capture[p])
      |=> !stickyVec[p]); // R9

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (stickyVec[p] && !(regWrEn && regAddr == ADDR_STATUS && regWrData[p]))
      |=> stickyVec[p]); // R10

    AST_NO_CAPTURE_SRC3: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe.capture[p] |-> (capStrobe.domain[p] != 2'd3)); // R4
  end

  AST_FIXED_PIN_SRC0: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe.capture[FIXED_PIN] |-> (capStrobe.domain[FIXED_PIN] == '0)); // R5

  AST_FIXED_PIN_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CFG + ADDR_W'(FIXED_PIN)) |-> (regRdData[DOM_LSB +: DOM_W] == '0)); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((|enableVec) && (|stickyVec))); // R11
endmodule

bind evt_stamp evt_stamp_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
  .capStrobe(capStrobe), .stickyVec(stickyVec), .enableVec(enableVec)
);

// File: tb/sim_evt_stamp.sv
`timescale 1ns/1ps
module sim_evt_stamp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic [191:0] todSec = '0;
  logic [89:0]  todNs = '0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_stamp u0 (.clk(clk), .rstN(rstN), .pinIn(pinIn), .todSec(todSec), .todNs(todNs),
                .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
                .regRdData(regRdData), .irqOut(irqOut));

  typedef struct packed {
    logic [2:0]  chan;
    logic [2:0]  sel;
    logic [1:0]  dom;
    logic [63:0] sec;
    logic [29:0] ns;
    logic        expCap;
  } vecT;

  localparam int NVEC = 6;
  localparam vecT VECS [NVEC] = '{
    '{3'd0, 3'd0, 2'd0, 64'h0000_0001_0000_0005, 30'd123,        1'b1},
    '{3'd3, 3'd3, 2'd2, 64'h1234_5678_9ABC_DEF0, 30'h3FFFFFF5,   1'b1},
    '{3'd5, 3'd1, 2'd1, 64'h0000_0002_0000_0000, 30'h3FFFFFF0,   1'b1},
    '{3'd7, 3'd7, 2'd2, 64'h0000_00AA_0000_0BBB, 30'h3FFFFFEF,   1'b1},
    '{3'd2, 3'd6, 2'd3, 64'h0000_0000_0000_0005, 30'd9,          1'b0},
    '{3'd6, 3'd4, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 30'h3FFFFFFF,   1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] cfgBits(input logic [1:0] act, input logic [1:0] arm,
                                          input logic [1:0] dom, input logic [2:0] sel);
    return {8'd0, sel, 3'd0, dom, 10'd0, arm, 2'd0, act};
  endfunction

  // rise, then stop at the falling clock edge after the third rising edge
  task automatic pulse(input int pin);
    @(negedge clk);
    pinIn[pin] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop(input int pin);
    pinIn[pin] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setTod(input int d, input logic [63:0] s, input logic [29:0] n);
    todSec[d*64 +: 64] = s;
    todNs[d*30 +: 30] = n;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired, run hung (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hi, lo, ns;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    rd(6'h00, d); chk("R1 status", d, 0);
    rd(6'h01, d); chk("R1 enable", d, 0);
    rd(6'h08, d); chk("R1 cfg0", d, 0);
    rd(6'h10, d); chk("R1 sechi0", d, 0);
    chk("R1 irq", irqOut, 0);

    // readback of configuration and enable
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, d); chk("R12 cfg4 readback", d, 32'h00E3_0033);
    wr(6'h0F, 32'hFFFF_FFFF); rd(6'h0F, d); chk("R5 cfg7 source reads 0", d, 32'h00E0_0033);
    wr(6'h01, 32'hFFFF_FFFF); rd(6'h01, d); chk("R12 enable readback", d, 32'h0000_00FF);
    wr(6'h01, 0); wr(6'h0C, 0); wr(6'h0F, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vecT v;
      int effDom;
      logic [63:0] es;
      logic [29:0] en;
      v = VECS[i];
      effDom = (v.chan == 3'd7) ? 0 : int'(v.dom);
      for (int dd = 0; dd < 3; dd++)
        setTod(dd, v.sec + 64'h1_0000_1000 * (dd + 1), 30'(dd + 7));
      if (effDom < 3) setTod(effDom, v.sec, v.ns);
      if (v.ns >= 30'h3FFFFFF0) begin
        es = v.sec - 64'd1;
        en = v.ns - 30'h3FFFFFF0 + 30'd999999984;
      end else begin
        es = v.sec;
        en = v.ns;
      end
      wr(6'h08 + 6'(v.chan), cfgBits(2'd1, 2'd3, v.dom, v.sel));
      wr(6'h00, 32'hFF);
      pulse(int'(v.sel));
      rd(6'h00, d);
      chk("R6 R4 status pattern", d, v.expCap ? (32'd1 << v.chan) : 32'd0);
      rd(6'h10 + 6'(v.chan), hi);
      rd(6'h18 + 6'(v.chan), lo);
      rd(6'h20 + 6'(v.chan), ns);
      if (v.expCap) begin
        chk("R7 R8 seconds", {hi, lo}, es);
        chk("R7 R8 nanoseconds", ns, {2'b0, en});
      end else begin
        chk("R4 no stored time", {hi, lo}, 0);
      end
      drop(int'(v.sel));
    end
    rd(6'h0F, d); chk("R5 cfg7 source after write", d[17:16], 0);

    // latency and falling edge, channel 0 on input 0
    wr(6'h00, 32'hFF);
    @(negedge clk); pinIn[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rd(6'h00, d); chk("R3 not yet after two edges", d[0], 0);
    @(posedge clk);
    @(negedge clk); rd(6'h00, d); chk("R3 set after three edges", d[0], 1);
    wr(6'h00, 32'h01);
    drop(0);
    @(negedge clk); rd(6'h00, d); chk("R3 falling edge ignored", d[0], 0);

    // overwrite while sticky
    setTod(0, 64'h0000_0010_0000_0020, 30'd30);
    pulse(0); drop(0);
    setTod(0, 64'h0000_0040_0000_0050, 30'd60);
    pulse(0);
    rd(6'h00, d); chk("R10 status stays set", d[0], 1);
    rd(6'h18, lo); chk("R10 new time stored", lo, 32'h50);
    rd(6'h20, ns); chk("R10 new ns stored", ns, 60);
    drop(0);

    // capture and clearing write in the same cycle
    @(negedge clk); pinIn[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); regWrEn = 1'b1; regAddr = 6'h00; regWrData = 32'h01;
    @(posedge clk);
    @(negedge clk); regWrEn = 1'b0;
    rd(6'h00, d); chk("R9 capture beats clear", d[0], 1);
    wr(6'h00, 32'h01);
    rd(6'h00, d); chk("R9 write one clears", d[0], 0);
    drop(0);

    // arming rules, channel 1 on input 2
    wr(6'h09, cfgBits(2'd1, 2'd0, 2'd0, 3'd2));
    pulse(2); rd(6'h00, d); chk("R2 arm 0 no capture", d[1], 0); drop(2);
    wr(6'h09, cfgBits(2'd0, 2'd3, 2'd0, 3'd2));
    pulse(2); rd(6'h00, d); chk("R2 idle no capture", d[1], 0); drop(2);
    wr(6'h09, cfgBits(2'd1, 2'd3, 2'd0, 3'd2));
    pulse(2); rd(6'h00, d); chk("R2 armed captures", d[1], 1); drop(2);

    // interrupt masking
    wr(6'h01, 32'h00); chk("R11 irq masked", irqOut, 0);
    wr(6'h01, 32'h02); chk("R11 irq enabled", irqOut, 1);
    wr(6'h01, 32'hFD); chk("R11 other bits only", irqOut, 0);
    wr(6'h01, 32'hFF); wr(6'h00, 32'h02);
    chk("R11 irq drops after clear", irqOut, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule